// File: doc/BRIEF.md
# Engine Clock Gating Controller with Keyed Request Register

This block controls the clock enables of five accelerator engines, one enable per engine. Software sets the controller up through a small register port. A mode register chooses how each engine is gated. In direct mode the clock enable simply tracks the engine's request bit. In handshake mode the controller first asks the engine to go quiet and waits for its acknowledge before it removes the clock.

The request register holds one bit per engine: 1 means the clock should run and 0 means it should be gated. Bits [31:28] of a write to this register are a key that selects how the write applies. One key value makes the write set bits only and another makes it clear bits only. Either way, one engine's request can change without a read-modify-write that could race with other writers. Any other key makes the write an ordinary overwrite. The gate cells and the engines are outside this block.

Top module: `engine_clkgate_ctrl`

## Requirements
- R1: After reset every `clk_en` and `idle_req` bit is 0, and both the mode register and the request register read back as 0.
- R2: The mode register is at address 0x000. A write stores `bus_wdata[4:0]`, where bit n set to 1 selects handshake mode for engine n and 0 selects direct mode. Reads return the stored bits in [4:0] and zeros in [31:5].
- R3: A write to address 0x004 with `bus_wdata[31:28]` = 0x5 sets every request bit written as 1. Request bits written as 0 keep their value.
- R4: A write to address 0x004 with `bus_wdata[31:28]` = 0x2 clears every request bit written as 1. Request bits written as 0 keep their value.
- R5: A write to address 0x004 with any other key value replaces request bits [4:0] with `bus_wdata[4:0]`.
- R6: A read of address 0x004 returns the request bits in [4:0] and zeros in [31:5], including zeros in the key field [31:28].
- R7: For an engine in direct mode, `clk_en` equals its request bit one cycle after the register updates, and its `idle_req` stays 0.
- R8: For an engine in handshake mode, clearing its request bit raises `idle_req` one cycle later while `clk_en` stays 1. `clk_en` drops on the cycle after a clock edge that sees both `idle_req` and `idle_ack` high. `idle_req` then stays high while the engine is gated.
- R9: For a gated engine in handshake mode, setting its request bit raises `clk_en` one cycle later, and `idle_req` falls one cycle after that.
- R10: A write to any address other than 0x000 and 0x004 changes no register, and a read of such an address returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 12 | Byte address for reads and writes |
| bus_wdata | input | 32 | Write data, including the key in [31:28] |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| idle_ack | input | 5 | Per-engine acknowledge that the engine is idle |
| idle_req | output | 5 | Per-engine request to go idle |
| clk_en | output | 5 | Per-engine clock enable, 1 = clock runs |

## Verification
The bound checker watches several properties on every cycle. It checks the set-only, clear-only and overwrite results of each request write, and that unmapped writes leave both registers unchanged. It also checks that the key field always reads as zero and that direct-mode enables track the request one cycle later. For handshake mode it checks that a clock never stops without a prior acknowledged idle request, and that `idle_req` is released only while the clock runs. Some things only the bench scenarios can show: the reset values, the exact cycle on which `idle_req` rises, and that the enable holds while the acknowledge stays low. They also show that the enable returns before the request falls, and that mixed-mode engines work side by side.

// File: rtl/cgc_pkg.sv
package cgc_pkg;

    localparam logic [3:0] KEY_SET = 4'h5;
    localparam logic [3:0] KEY_CLR = 4'h2;

    typedef enum logic [1:0] {
        WR_PLAIN = 2'd0,
        WR_SET   = 2'd1,
        WR_CLR   = 2'd2
    } wr_kind_e;

    typedef struct packed {
        logic en;
        logic ireq;
    } lane_t;

    function automatic wr_kind_e decode_key(input logic [3:0] key);
        if (key == KEY_SET)      return WR_SET;
        else if (key == KEY_CLR) return WR_CLR;
        else                     return WR_PLAIN;
    endfunction

endpackage

// File: rtl/cgc_regs.sv
module cgc_regs
    import cgc_pkg::*;
#(
    parameter int NUM_ENG = 5,
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 12,
    parameter logic [ADDR_W-1:0] MODE_OFS = '0,
    parameter logic [ADDR_W-1:0] REQ_OFS  = ADDR_W'(4)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic [NUM_ENG-1:0] mode_q,
    output logic [NUM_ENG-1:0] req_q
);
    localparam int KEY_MSB = DATA_W - 1;

    typedef struct packed {
        logic [NUM_ENG-1:0] mode;
        logic [NUM_ENG-1:0] req;
    } regs_t;

    regs_t r_d, r_q;
    logic [NUM_ENG-1:0] wbits;
    wr_kind_e           kind;

    always_comb begin
        wbits = bus_wdata[NUM_ENG-1:0];
        kind  = decode_key(bus_wdata[KEY_MSB -: 4]);
        r_d   = r_q;
        if (bus_wr && bus_addr == MODE_OFS) begin
            r_d.mode = wbits;
        end
        if (bus_wr && bus_addr == REQ_OFS) begin
            case (kind)
                WR_SET:  r_d.req = r_q.req | wbits;
                WR_CLR:  r_d.req = r_q.req & ~wbits;
                default: r_d.req = wbits;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        if (bus_addr == MODE_OFS)     bus_rdata = DATA_W'(r_q.mode);
        else if (bus_addr == REQ_OFS) bus_rdata = DATA_W'(r_q.req);
        else                          bus_rdata = '0;
    end

    assign mode_q = r_q.mode;
    assign req_q  = r_q.req;

endmodule

// File: rtl/cgc_lane.sv
module cgc_lane
    import cgc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hs_mode,
    input  logic run_req,
    input  logic idle_ack,
    output logic clk_en,
    output logic idle_req
);
    lane_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (!hs_mode) begin
            s_d.en   = run_req;
            s_d.ireq = 1'b0;
        end else if (!run_req) begin
            if (s_q.en && !s_q.ireq)              s_d.ireq = 1'b1;
            else if (s_q.en && s_q.ireq && idle_ack) s_d.en = 1'b0;
        end else begin
            if (!s_q.en)       s_d.en   = 1'b1;
            else if (s_q.ireq) s_d.ireq = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign clk_en   = s_q.en;
    assign idle_req = s_q.ireq;

endmodule

// File: rtl/engine_clkgate_ctrl.sv
module engine_clkgate_ctrl #(
    parameter int NUM_ENG = 5,
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    input  logic [NUM_ENG-1:0] idle_ack,
    output logic [NUM_ENG-1:0] idle_req,
    output logic [NUM_ENG-1:0] clk_en
);
    localparam logic [ADDR_W-1:0] MODE_OFS = '0;
    localparam logic [ADDR_W-1:0] REQ_OFS  = ADDR_W'(4);

    logic [NUM_ENG-1:0] mode_q;
    logic [NUM_ENG-1:0] req_q;

    cgc_regs #(
        .NUM_ENG (NUM_ENG),
        .DATA_W  (DATA_W),
        .ADDR_W  (ADDR_W),
        .MODE_OFS(MODE_OFS),
        .REQ_OFS (REQ_OFS)
    ) i_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .mode_q   (mode_q),
        .req_q    (req_q)
    );

    for (genvar g = 0; g < NUM_ENG; g++) begin : g_lane
        cgc_lane i_lane (
            .clk     (clk),
            .rst_n   (rst_n),
            .hs_mode (mode_q[g]),
            .run_req (req_q[g]),
            .idle_ack(idle_ack[g]),
            .clk_en  (clk_en[g]),
            .idle_req(idle_req[g])
        );
    end

endmodule

// File: rtl/cgc_checker.sv
module cgc_checker #(
    parameter int NUM_ENG = 5,
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 12
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bus_wr,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic [DATA_W-1:0]  bus_wdata,
    input logic [DATA_W-1:0]  bus_rdata,
    input logic [NUM_ENG-1:0] mode_q,
    input logic [NUM_ENG-1:0] req_q,
    input logic [NUM_ENG-1:0] idle_ack,
    input logic [NUM_ENG-1:0] idle_req,
    input logic [NUM_ENG-1:0] clk_en
);
    localparam logic [ADDR_W-1:0] MODE_OFS = '0;
    localparam logic [ADDR_W-1:0] REQ_OFS  = ADDR_W'(4);

    logic       req_wr;
    logic [3:0] key;
    logic       mapped;

    assign req_wr = bus_wr && (bus_addr == REQ_OFS);
    assign key    = bus_wdata[DATA_W-1 -: 4];
    assign mapped = (bus_addr == MODE_OFS) || (bus_addr == REQ_OFS);

    assert_set_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_wr && key == 4'h5) |=> req_q == ($past(req_q) | $past(bus_wdata[NUM_ENG-1:0])));

    assert_clear_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_wr && key == 4'h2) |=> req_q == ($past(req_q) & ~$past(bus_wdata[NUM_ENG-1:0])));

    assert_plain_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_wr && key != 4'h5 && key != 4'h2) |=> req_q == $past(bus_wdata[NUM_ENG-1:0]));

    assert_key_reads_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == REQ_OFS) |-> bus_rdata[DATA_W-1:NUM_ENG] == '0);

    assert_direct_follow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((clk_en ^ $past(req_q)) & ~$past(mode_q)) == '0);

    assert_direct_no_idle_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_req & ~$past(mode_q)) == '0);

    assert_gate_needs_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(clk_en) & ~clk_en & $past(mode_q) & ~$past(idle_req & idle_ack)) == '0);

    assert_release_while_running_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(idle_req) & ~idle_req & $past(mode_q) & ~clk_en) == '0);

    assert_unmapped_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !mapped) |=> ($stable(req_q) && $stable(mode_q)));

endmodule

bind engine_clkgate_ctrl cgc_checker #(
    .NUM_ENG(NUM_ENG),
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
) i_cgc_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .mode_q   (mode_q),
    .req_q    (req_q),
    .idle_ack (idle_ack),
    .idle_req (idle_req),
    .clk_en   (clk_en)
);

// File: tb/test_engine_clkgate_ctrl.sv
`timescale 1ns/1ps
module test_engine_clkgate_ctrl;
    localparam int NE = 5;
    localparam int DW = 32;
    localparam int AW = 12;

    localparam int K_EN   = 0;
    localparam int K_IREQ = 1;
    localparam int K_RD   = 2;

    typedef struct {
        int          cyc;
        int          kind;
        logic [31:0] exp;
        string       tag;
    } item_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic [NE-1:0] idle_ack = '0;
    logic [NE-1:0] idle_req;
    logic [NE-1:0] clk_en;

    int    cyc = 0;
    int    checks = 0;
    int    fails = 0;
    item_t q[$];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    engine_clkgate_ctrl #(.NUM_ENG(NE), .DATA_W(DW), .ADDR_W(AW)) i_engine_clkgate_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .idle_ack(idle_ack),
        .idle_req(idle_req), .clk_en(clk_en)
    );

    task automatic expect_at(input int dly, input int kind, input logic [31:0] exp, input string tag);
        item_t it;
        it.cyc = cyc + dly; it.kind = kind; it.exp = exp; it.tag = tag;
        q.push_back(it);
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd_check(input logic [AW-1:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        bus_addr = a;
        expect_at(0, K_RD, exp, tag);
    endtask

    // monitor: compares queued expectations shortly after each falling edge
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (q.size() > 0 && q[0].cyc <= cyc) begin
                item_t it;
                logic [31:0] act;
                it = q.pop_front();
                case (it.kind)
                    K_EN:    act = 32'(clk_en);
                    K_IREQ:  act = 32'(idle_req);
                    default: act = bus_rdata;
                endcase
                checks++;
                if (act !== it.exp) begin
                    fails++;
                    $display("FAIL %s kind=%0d cycle=%0d actual=%h expected=%h",
                             it.tag, it.kind, cyc, act, it.exp);
                end
            end
        end
    end

    initial begin
        bit wd_hit;
        wd_hit = 1'b0;
        fork
            begin
                repeat (3) @(negedge clk);
                rst_n = 1'b1;
                // R1: reset state
                expect_at(0, K_EN, 32'h0, "R1 clk_en after reset");
                expect_at(0, K_IREQ, 32'h0, "R1 idle_req after reset");
                rd_check(12'h000, 32'h0, "R1 mode reg after reset");
                rd_check(12'h004, 32'h0, "R1 request reg after reset");

                // R5 plain write, R7 direct follow
                wr(12'h004, 32'h0000_0015);
                expect_at(1, K_EN, 32'h15, "R7 direct enables follow request");
                expect_at(1, K_IREQ, 32'h0, "R7 no idle_req in direct mode");
                rd_check(12'h004, 32'h15, "R5 plain write with key 0");

                // R3 set-only
                wr(12'h004, 32'h5000_0003);
                expect_at(1, K_EN, 32'h17, "R3 enables after set-only write");
                rd_check(12'h004, 32'h17, "R3 set-only keeps zero-written bits");

                // R4 clear-only
                wr(12'h004, 32'h2000_0005);
                rd_check(12'h004, 32'h12, "R4 clear-only keeps zero-written bits");

                // R5 other key, R6 key field reads zero
                wr(12'h004, 32'hF000_0009);
                rd_check(12'h004, 32'h09, "R6 key field reads 0 after key F write");
                expect_at(0, K_EN, 32'h09, "R7 enables after overwrite");

                // R10 unmapped address
                wr(12'h008, 32'hFFFF_FFFF);
                rd_check(12'h004, 32'h09, "R10 request unchanged by unmapped write");
                rd_check(12'h000, 32'h00, "R10 mode unchanged by unmapped write");
                rd_check(12'h008, 32'h00, "R10 unmapped read returns 0");

                // R2 mode register, only bits [4:0] stored
                wr(12'h000, 32'hFFFF_FFE1);
                rd_check(12'h000, 32'h01, "R2 mode reg stores bits [4:0]");

                // R8 handshake gating of engine 0, ack held low
                wr(12'h004, 32'h2000_0001);
                expect_at(0, K_EN, 32'h09, "R8 enable held at request clear");
                expect_at(1, K_IREQ, 32'h01, "R8 idle_req rises one cycle later");
                expect_at(1, K_EN, 32'h09, "R8 enable held while idle_req up");
                expect_at(4, K_EN, 32'h09, "R8 enable held without ack");
                repeat (5) @(negedge clk);
                idle_ack = 5'b00001;
                expect_at(1, K_EN, 32'h08, "R8 enable drops after ack seen");
                expect_at(1, K_IREQ, 32'h01, "R8 idle_req held while gated");
                repeat (2) @(negedge clk);
                idle_ack = '0;

                // R9 handshake un-gating
                wr(12'h004, 32'h5000_0001);
                expect_at(1, K_EN, 32'h09, "R9 enable returns one cycle later");
                expect_at(1, K_IREQ, 32'h01, "R9 idle_req still up with enable back");
                expect_at(2, K_IREQ, 32'h00, "R9 idle_req falls after enable");
                repeat (4) @(negedge clk);
            end
            begin
                repeat (20000) @(posedge clk);
                wd_hit = 1'b1;
            end
        join_any
        disable fork;
        if (wd_hit) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired actual=hung expected=finished");
        end
        while (q.size() > 0) begin
            item_t it;
            it = q.pop_front();
            checks++;
            fails++;
            $display("FAIL %s never compared actual=none expected=%h", it.tag, it.exp);
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule